// File: doc/BRIEF.md
# Pipelined Store Write Buffer

This block is the store path of a direct-mapped data cache. It splits every store into two stages. In the request cycle the store's tag is compared against the tag array. The byte write into the data array is postponed and happens in the cycle the next store arrives, so that store's tag check and the previous store's array update share one cycle. A one-entry pending-write register sits between the two stages. It holds the address, the data word and the byte enables of the store that has been checked but not yet written.

Loads do not pass through the pending register. They read the data array in their request cycle and never stall on a hit. Every load compares its full address against the pending register. On a match, each byte enabled in the pending store is taken from the register and every other byte comes from the array. A miss of either kind raises a stall for that cycle and empties the pending register by writing the held store into the array. Refill is handled outside the block.

Two more events write the pending store without a following store. The first is a flush request. The second is a run of cycles with no store, of a length set by parameter.

Top module: `stwb_pipe`

## Requirements
- R1: During and right after reset, the block holds no pending store: `arr_we`, `rsp_hit`, `rsp_miss` and `stall` are 0, and `ld_data` is 0.
- R2: A request is a hit when `tag_rd_valid` is 1 and `tag_rd_tag` equals the upper `ADDR_W-IDX_W` bits of `req_addr`. `tag_idx` is the lower `IDX_W` bits. `rsp_hit` or `rsp_miss` is reported in the request cycle. A store that hits is held as the pending store and is not written to the array in its own cycle.
- R3: When a store request arrives while a store is pending, the pending store is written in that same cycle. `arr_we` is 1, `arr_waddr` is the pending index, and `arr_wdata` and `arr_wbe` are the pending data and enables. Byte b covers data bits 8b+7..8b.
- R4: A load hit whose full address equals the pending address returns, in its request cycle, the pending bytes where the pending enable bit is 1 and the array bytes elsewhere. It does not stall.
- R5: A load hit to any other address returns the array word at its index in the request cycle, with `stall` at 0.
- R6: A load hit neither writes the array nor alters the pending store. The store later reaches the array with its original address, data and enables.
- R7: A store miss raises `rsp_miss` and `stall` for its cycle and writes any pending store in that cycle. The missing store itself is dropped and never reaches the array.
- R8: A load miss raises `rsp_miss` and `stall` and writes any pending store in that cycle. `ld_data` is 0 in that cycle.
- R9: If no store arrives for `IDLE_LIMIT` cycles after a store is captured, the pending store is written in the `IDLE_LIMIT`-th cycle after the capturing edge.
- R10: `flush_req` writes any pending store in the same cycle. If no store hit is captured in that cycle, the register is empty afterwards.
- R11: The array receives only stores whose tag check hit, each at most once. After a drain, every resident line equals a flat memory that applies each hitting store at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address: tag in the upper bits, index in the lower bits |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| flush_req | input | 1 | Write any pending store now |
| ld_data | output | DATA_W | Load result, valid on a load hit |
| rsp_hit | output | 1 | Tag check hit |
| rsp_miss | output | 1 | Tag check miss |
| stall | output | 1 | Pipeline must hold (miss) |
| tag_idx | output | IDX_W | Tag array read index |
| tag_rd_tag | input | ADDR_W-IDX_W | Tag read back (combinational) |
| tag_rd_valid | input | 1 | Line valid bit read back |
| arr_raddr | output | IDX_W | Data array read index |
| arr_rdata | input | DATA_W | Data array read word (combinational) |
| arr_we | output | 1 | Data array write strobe |
| arr_waddr | output | IDX_W | Data array write index |
| arr_wdata | output | DATA_W | Data array write word |
| arr_wbe | output | DATA_W/8 | Data array byte write enables |

## Verification
A pending register that holds a wrong address, data or enable mask shows up in one of two places. A later load to that address returns bytes that differ from the flat reference in its own request cycle. Otherwise the write strobe fields differ from expectation in the cycle the next store, miss, flush or idle expiry drains the register. A wrong idle count makes `arr_we` appear one or more cycles early or late within `IDLE_LIMIT` cycles. A lost or doubled commit leaves the array different from the reference by the final drain, and usually much sooner through a later load of that line.

// File: rtl/stwb_pkg.sv
package stwb_pkg;

    // Reason the pending store is written to the array this cycle.
    typedef enum logic [2:0] {
        CM_NONE  = 3'd0,
        CM_STORE = 3'd1,
        CM_MISS  = 3'd2,
        CM_FLUSH = 3'd3,
        CM_IDLE  = 3'd4
    } commit_cause_e;

endpackage

// File: rtl/stwb_tag_cmp.sv
module stwb_tag_cmp #(
    parameter int TAG_W = 4
) (
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             rd_valid,
    output logic             hit
);
    always_comb begin
        hit = rd_valid && (rd_tag == req_tag);
    end
endmodule

// File: rtl/stwb_fwd_merge.sv
module stwb_fwd_merge #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic [DATA_W-1:0]   arr_word,
    input  logic                pend_valid,
    input  logic [ADDR_W-1:0]   pend_addr,
    input  logic [DATA_W-1:0]   pend_data,
    input  logic [DATA_W/8-1:0] pend_be,
    output logic [DATA_W-1:0]   merged
);
    localparam int BE_W = DATA_W / 8;

    logic addr_match;

    always_comb begin
        addr_match = pend_valid && (pend_addr == ld_addr);
    end

    // Per-byte selection: pending byte when enabled and matching, array otherwise.
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        always_comb begin
            if (addr_match && pend_be[b]) begin
                merged[b*8 +: 8] = pend_data[b*8 +: 8];
            end else begin
                merged[b*8 +: 8] = arr_word[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/stwb_pend_reg.sv
module stwb_pend_reg
    import stwb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int IDLE_LIMIT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                store_arrive,
    input  logic                miss_drain,
    input  logic                flush,
    input  logic [ADDR_W-1:0]   cap_addr,
    input  logic [DATA_W-1:0]   cap_data,
    input  logic [DATA_W/8-1:0] cap_be,
    output logic                pend_valid,
    output logic [ADDR_W-1:0]   pend_addr,
    output logic [DATA_W-1:0]   pend_data,
    output logic [DATA_W/8-1:0] pend_be,
    output logic                commit
);
    localparam int BE_W  = DATA_W / 8;
    localparam int CNT_W = $clog2(IDLE_LIMIT + 1);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic [CNT_W-1:0]  idle;
    } pend_t;

    pend_t         st_d, st_q;
    commit_cause_e cause;

    always_comb begin
        cause = CM_NONE;
        if (st_q.valid) begin
            if (miss_drain) begin
                cause = CM_MISS;
            end else if (store_arrive) begin
                cause = CM_STORE;
            end else if (flush) begin
                cause = CM_FLUSH;
            end else if (st_q.idle == CNT_W'(IDLE_LIMIT - 1)) begin
                cause = CM_IDLE;
            end
        end
        commit = (cause != CM_NONE);

        st_d = st_q;
        if (capture) begin
            st_d.valid = 1'b1;
            st_d.addr  = cap_addr;
            st_d.data  = cap_data;
            st_d.be    = cap_be;
            st_d.idle  = '0;
        end else if (commit) begin
            st_d.valid = 1'b0;
            st_d.idle  = '0;
        end else if (st_q.valid) begin
            st_d.idle  = st_q.idle + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_valid = st_q.valid;
    assign pend_addr  = st_q.addr;
    assign pend_data  = st_q.data;
    assign pend_be    = st_q.be;

    a_r9_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.idle < CNT_W'(IDLE_LIMIT)));

    a_r9_idle_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !capture && st_q.idle == CNT_W'(IDLE_LIMIT - 1)) |=> !st_q.valid);

    a_r2_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (st_q.valid && st_q.addr == $past(cap_addr)
                     && st_q.data == $past(cap_data) && st_q.be == $past(cap_be)));

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !commit) |=> ($stable(st_q.addr) && $stable(st_q.data)
                                   && $stable(st_q.be) && $stable(st_q.valid)));

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !capture) |=> !st_q.valid);
endmodule

// File: rtl/stwb_pipe.sv
module stwb_pipe #(
    parameter int ADDR_W     = 8,
    parameter int IDX_W      = 4,
    parameter int DATA_W     = 32,
    parameter int IDLE_LIMIT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_store,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/8-1:0]      req_be,
    input  logic                     flush_req,
    output logic [DATA_W-1:0]        ld_data,
    output logic                     rsp_hit,
    output logic                     rsp_miss,
    output logic                     stall,
    output logic [IDX_W-1:0]         tag_idx,
    input  logic [ADDR_W-IDX_W-1:0]  tag_rd_tag,
    input  logic                     tag_rd_valid,
    output logic [IDX_W-1:0]         arr_raddr,
    input  logic [DATA_W-1:0]        arr_rdata,
    output logic                     arr_we,
    output logic [IDX_W-1:0]         arr_waddr,
    output logic [DATA_W-1:0]        arr_wdata,
    output logic [DATA_W/8-1:0]      arr_wbe
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int BE_W  = DATA_W / 8;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic              lookup_hit;
    logic              store_arrive;
    logic              capture;
    logic              miss_drain;
    logic              load_hit;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic [BE_W-1:0]   pend_be;
    logic [DATA_W-1:0] merged;
    logic              commit;

    always_comb begin
        req_tag      = req_addr[ADDR_W-1:IDX_W];
        req_idx      = req_addr[IDX_W-1:0];
        store_arrive = req_valid && req_store;
        capture      = store_arrive && lookup_hit;
        miss_drain   = req_valid && !lookup_hit;
        load_hit     = req_valid && !req_store && lookup_hit;
    end

    stwb_tag_cmp #(.TAG_W(TAG_W)) u_tag_cmp (
        .req_tag  (req_tag),
        .rd_tag   (tag_rd_tag),
        .rd_valid (tag_rd_valid),
        .hit      (lookup_hit)
    );

    stwb_pend_reg #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .store_arrive (store_arrive),
        .miss_drain   (miss_drain),
        .flush        (flush_req),
        .cap_addr     (req_addr),
        .cap_data     (req_wdata),
        .cap_be       (req_be),
        .pend_valid   (pend_valid),
        .pend_addr    (pend_addr),
        .pend_data    (pend_data),
        .pend_be      (pend_be),
        .commit       (commit)
    );

    stwb_fwd_merge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_merge (
        .ld_addr    (req_addr),
        .arr_word   (arr_rdata),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_data  (pend_data),
        .pend_be    (pend_be),
        .merged     (merged)
    );

    always_comb begin
        tag_idx   = req_idx;
        arr_raddr = req_idx;
        rsp_hit   = req_valid && lookup_hit;
        rsp_miss  = miss_drain;
        stall     = miss_drain;
        ld_data   = load_hit ? merged : '0;
        arr_we    = commit;
        arr_waddr = pend_addr[IDX_W-1:0];
        arr_wdata = pend_data;
        arr_wbe   = pend_be;
    end

    a_r3_store_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && pend_valid) |-> arr_we);

    a_r7_miss_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && !lookup_hit) |=> !pend_valid);

    a_r8_load_miss_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && !lookup_hit) |=> !pend_valid);

    for (genvar b = 0; b < BE_W; b++) begin : g_fwd_chk
        a_r4_fwd_byte: assert property (@(posedge clk) disable iff (!rst_n)
            (load_hit && pend_valid && pend_addr == req_addr && pend_be[b])
            |-> (ld_data[b*8 +: 8] == pend_data[b*8 +: 8]));
        a_r5_array_byte: assert property (@(posedge clk) disable iff (!rst_n)
            (load_hit && !(pend_valid && pend_addr == req_addr && pend_be[b]))
            |-> (ld_data[b*8 +: 8] == arr_rdata[b*8 +: 8]));
    end
endmodule

// File: tb/stwb_pipe_tb.sv
`timescale 1ns/1ps
module stwb_pipe_tb_top;
    localparam int LIM = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        flush_req = 1'b0;
    logic [31:0] ld_data;
    logic        rsp_hit, rsp_miss, stall;
    logic [3:0]  tag_idx, arr_raddr, arr_waddr;
    logic [3:0]  tag_rd_tag;
    logic        tag_rd_valid;
    logic [31:0] arr_rdata, arr_wdata;
    logic        arr_we;
    logic [3:0]  arr_wbe;

    logic [3:0]  tag_mem [16];
    logic        tag_v   [16];
    logic [31:0] data_mem[16];
    logic [31:0] ref_mem [256];

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic        m_pv = 1'b0;
    logic [7:0]  m_pa = '0;
    logic [31:0] m_pd = '0;
    logic [3:0]  m_pbe = '0;
    int          m_idle = 0;
    logic [31:0] rng = 32'h1234_5679;

    always #4 clk = ~clk;

    stwb_pipe #(.ADDR_W(8), .IDX_W(4), .DATA_W(32), .IDLE_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .flush_req(flush_req), .ld_data(ld_data), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .stall(stall), .tag_idx(tag_idx),
        .tag_rd_tag(tag_rd_tag), .tag_rd_valid(tag_rd_valid),
        .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .arr_we(arr_we),
        .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .arr_wbe(arr_wbe)
    );

    assign tag_rd_tag   = tag_mem[tag_idx];
    assign tag_rd_valid = tag_v[tag_idx];
    assign arr_rdata    = data_mem[arr_raddr];

    always @(posedge clk) begin
        if (arr_we) begin
            for (int b = 0; b < 4; b++)
                if (arr_wbe[b]) data_mem[arr_waddr][b*8 +: 8] <= arr_wdata[b*8 +: 8];
        end
    end

    function automatic logic [31:0] init_val(int a);
        return (32'h9E37_79B1 * (a + 1)) ^ (a << 12);
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] next_rng(logic [31:0] x);
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One request cycle: drive at the falling edge, check before the rising edge.
    task automatic op(bit v, bit st, logic [7:0] a, logic [31:0] d, logic [3:0] be,
                      bit fl, string rq);
        bit hit, cm;
        @(negedge clk);
        req_valid = v; req_store = st; req_addr = a; req_wdata = d; req_be = be;
        flush_req = fl;
        #2;
        hit = tag_v[a[3:0]] && (tag_mem[a[3:0]] == a[7:4]);
        cm  = m_pv && ((v && st) || (v && !hit) || fl || (m_idle == LIM - 1));
        chk(rsp_hit == (v && hit), rq, "rsp_hit", 32'(rsp_hit), 32'(v && hit));
        chk(rsp_miss == (v && !hit), rq, "rsp_miss", 32'(rsp_miss), 32'(v && !hit));
        chk(stall == (v && !hit), rq, "stall", 32'(stall), 32'(v && !hit));
        chk(arr_we == cm, rq, "arr_we", 32'(arr_we), 32'(cm));
        if (cm && arr_we) begin
            chk(arr_waddr == m_pa[3:0], rq, "arr_waddr", 32'(arr_waddr), 32'(m_pa[3:0]));
            chk(arr_wdata == m_pd, rq, "arr_wdata", arr_wdata, m_pd);
            chk(arr_wbe == m_pbe, rq, "arr_wbe", 32'(arr_wbe), 32'(m_pbe));
        end
        if (v && !st && hit)
            chk(ld_data == ref_mem[a], rq, "ld_data", ld_data, ref_mem[a]);
        if (v && !st && !hit)
            chk(ld_data == 32'd0, rq, "ld_data on miss", ld_data, 32'd0);
        if (v && st && hit) begin
            ref_mem[a] = merge(ref_mem[a], d, be);
            m_pv = 1'b1; m_pa = a; m_pd = d; m_pbe = be; m_idle = 0;
        end else if (cm) begin
            m_pv = 1'b0; m_idle = 0;
        end else if (m_pv) begin
            m_idle++;
        end
    endtask

    // Bench-side line replacement; only while nothing is pending.
    task automatic refill(int idx, logic [3:0] t);
        @(negedge clk);
        req_valid = 1'b0; flush_req = 1'b0;
        tag_mem[idx]  = t;
        data_mem[idx] = ref_mem[{t, 4'(idx)}];
        #2;
    endtask

    function automatic logic [7:0] res_addr(int idx);
        return {tag_mem[idx], 4'(idx)};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) ref_mem[a] = init_val(a);
        for (int i = 0; i < 16; i++) begin
            tag_mem[i]  = 4'((i * 5 + 3) & 15);
            tag_v[i]    = (i != 15);
            data_mem[i] = ref_mem[{tag_mem[i], 4'(i)}];
        end

        // R1: reset state
        repeat (2) @(negedge clk);
        #2;
        chk(arr_we == 1'b0, "R1", "arr_we", 32'(arr_we), 0);
        chk(rsp_hit == 1'b0, "R1", "rsp_hit", 32'(rsp_hit), 0);
        chk(rsp_miss == 1'b0, "R1", "rsp_miss", 32'(rsp_miss), 0);
        chk(stall == 1'b0, "R1", "stall", 32'(stall), 0);
        chk(ld_data == 32'd0, "R1", "ld_data", ld_data, 0);
        @(negedge clk); rst_n = 1'b1;
        op(0, 0, 8'h0, 0, 0, 0, "R1");

        // R2, R3, R4, R5, R6: every resident index with every enable mask
        for (int i = 0; i < 15; i++) begin
            for (int be = 1; be < 16; be++) begin
                op(1, 1, res_addr(i), init_val(i * 16 + be) ^ 32'h5A5A_0000, 4'(be), 0, "R2/R3");
                op(1, 0, res_addr(i), 0, 0, 0, "R4");
                op(1, 0, res_addr((i + 1) % 15), 0, 0, 0, "R5");
                op(1, 0, res_addr((i + 7) % 15), 0, 0, 0, "R6");
            end
        end

        // R9: idle expiry
        op(1, 1, res_addr(3), 32'hC0DE_0003, 4'b1010, 0, "R9");
        for (int k = 0; k < LIM + 2; k++) op(0, 0, 0, 0, 0, 0, "R9");
        op(1, 1, res_addr(2), 32'hC0DE_0002, 4'b0110, 0, "R9");
        for (int k = 0; k < LIM - 1; k++) op(1, 0, res_addr(2), 0, 0, 0, "R9");
        op(1, 0, res_addr(2), 0, 0, 0, "R9");

        // R10: flush
        op(1, 1, res_addr(6), 32'hF1F1_0006, 4'b1111, 0, "R10");
        op(0, 0, 0, 0, 0, 1, "R10");
        op(0, 0, 0, 0, 0, 1, "R10");
        op(1, 0, res_addr(6), 0, 0, 0, "R10");

        // R7: store miss drains and drops
        op(1, 1, res_addr(4), 32'hAAAA_0004, 4'b0011, 0, "R7");
        op(1, 1, {tag_mem[4] ^ 4'h8, 4'd4}, 32'hDEAD_BEEF, 4'b1111, 0, "R7");
        op(1, 0, res_addr(4), 0, 0, 0, "R7");
        op(1, 1, 8'h5F, 32'h1111_2222, 4'b1111, 0, "R7");
        op(0, 0, 0, 0, 0, 1, "R7");

        // R8: load miss drains
        op(1, 1, res_addr(5), 32'hBBBB_0005, 4'b1100, 0, "R8");
        op(1, 0, 8'hAF, 0, 0, 0, "R8");
        op(1, 0, res_addr(5), 0, 0, 0, "R8");

        // R11: mixed traffic with occasional line replacement
        for (int n = 0; n < 3000; n++) begin
            int idx, kind;
            logic [7:0] a;
            rng  = next_rng(rng);
            idx  = int'(rng[3:0]);
            kind = int'(rng[6:4]);
            if (rng[15:12] == 4'h0 && !m_pv && idx != 15)
                refill(idx, rng[19:16]);
            a = (rng[10:8] == 3'd0) ? {tag_mem[idx] ^ rng[23:20], 4'(idx)}
                                    : res_addr(idx);
            if (kind < 4)
                op(1, 1, a, next_rng(rng ^ 32'h00FF_00FF), rng[27:24], rng[31:29] == 3'd0, "R11");
            else if (kind < 7)
                op(1, 0, a, 0, 0, rng[31:29] == 3'd0, "R11");
            else
                op(0, 0, 0, 0, 0, rng[31:29] == 3'd0, "R11");
        end

        // R11: drained array equals the flat reference
        op(0, 0, 0, 0, 0, 1, "R11");
        op(0, 0, 0, 0, 0, 0, "R11");
        for (int i = 0; i < 15; i++)
            chk(data_mem[i] == ref_mem[res_addr(i)], "R11", "array line",
                data_mem[i], ref_mem[res_addr(i)]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule